// File: doc/BRIEF.md
# Embedded-Operation Status Flag Generator

This block forms the word a host sees on the data bus while an automatic program or erase runs inside the memory. The algorithm engine reports whether it is busy, whether it ran past its time limit, what kind of operation it is running, and the bit 7 value the host last wrote. The sector erase window state comes in on its own input. From these the block builds an 8-bit status byte. That byte carries a polarity flag for the written bit, a bit that flips on every read, a timeout flag, a phase flag and an erase-window flag.

The status byte is copied into every active byte lane of the selected bus width. When no operation is active, array read data passes straight through to the output. A timeout keeps the status word on the bus until the host issues a reset (abort) command, even after the engine stops.

Top module: `flag_gen_top`

## Requirements
- R1: While status is inactive (engine idle, erase window closed, no timeout held), `rdata` equals `array_rdata` on all 32 bits and `status_on` is 0.
- R2: While status is active during a program (`op_erase`=0), bit 7 of each active lane is the inverse of `wr_bit7`.
- R3: While status is active during an erase (`op_erase`=1), bit 7 of each active lane reads 0.
- R4: Bit 6 of each active lane inverts after every clock edge that has `rd_strobe` high while status is active. It keeps its value across edges without a strobe, and across strobes while status is inactive. It reads 0 on the first status after reset.
- R5: An `eng_timeout` sample sets bit 5 from the next cycle on. The flag, and with it `status_on`, stays set after `eng_busy` falls, until a clock edge with `abort_cmd` high.
- R6: Bit 4 reads 0 while no timeout is held. Once a timeout is held, it shows `op_erase` as sampled with the timeout: 0 for program, 1 for erase.
- R7: Bit 3 reads 1 only while an erase is active with the erase window closed (the erase itself has begun). It reads 0 while `win_open` is 1 and during programs.
- R8: Bits 2 to 0 of every active lane read 0.
- R9: `lane_mode` encodes 0 for lane 0 only, 1 for lanes 0 and 1, and 2 or 3 for all four lanes. Lane k occupies bits 8k+7 to 8k. Inactive lanes read 0 while status is active.
- R10: After reset no timeout is held and the toggle state is 0.
- R11: When `abort_cmd` and `eng_timeout` are sampled on the same edge, the abort wins and no timeout is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_erase | input | 1 | Operation kind: 0 program, 1 erase |
| wr_bit7 | input | 1 | Bit 7 value of the last written data |
| eng_busy | input | 1 | Algorithm engine running |
| eng_timeout | input | 1 | Engine reports time limit exceeded |
| win_open | input | 1 | Sector erase window still open |
| rd_strobe | input | 1 | One host read access per high cycle |
| abort_cmd | input | 1 | Reset command decoded; clears the held timeout |
| lane_mode | input | 2 | Bus width select |
| array_rdata | input | 32 | Array read data |
| rdata | output | 32 | Data returned to the host |
| status_on | output | 1 | Status word is being driven |

## Verification
A held timeout that is lost or stuck shows up as a wrong bit 5 and a wrong `status_on`, one cycle after the timeout or abort edge. A toggle register that misses a strobe leaves bit 6 unchanged on the read after a strobe, so a single pair of reads exposes it. A wrong phase latch shows as bit 4 once a timeout is held. Replication faults appear as soon as status is active in a wider lane mode. Faults in the polarity and window flags are combinational, so they are visible in the same cycle as the input change.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'd0,
    LANES_TWO  = 2'd1,
    LANES_ALL  = 2'd2,
    LANES_ALLB = 2'd3
  } lane_mode_e;

  // Assemble one status byte from the individual flags.
  function automatic logic [7:0] make_status(
    input logic erase,
    input logic wbit7,
    input logic tgl,
    input logic tout,
    input logic phase,
    input logic win_closed
  );
    logic [7:0] b;
    b    = '0;
    b[7] = erase ? 1'b0 : ~wbit7;
    b[6] = tgl;
    b[5] = tout;
    b[4] = tout & phase;
    b[3] = erase & win_closed;
    return b;
  endfunction

  // Number of byte lanes that carry status for a given mode.
  function automatic int unsigned lanes_used(input logic [1:0] mode, input int unsigned total);
    case (mode)
      LANES_ONE: return 1;
      LANES_TWO: return (total < 2) ? total : 2;
      default:   return total;
    endcase
  endfunction

endpackage

// File: rtl/flag_state.sv
module flag_state (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rd_strobe,
  input  logic eng_timeout,
  input  logic op_erase,
  input  logic abort_cmd,
  output logic tgl_q,
  output logic tout_q,
  output logic phase_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl_q   <= 1'b0;
      tout_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (active && rd_strobe) tgl_q <= ~tgl_q;
      if (abort_cmd) begin
        tout_q <= 1'b0;
      end else if (eng_timeout) begin
        tout_q  <= 1'b1;
        phase_q <= op_erase;
      end
    end
  end

endmodule

// File: rtl/lane_fanout.sv
module lane_fanout #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              active,
  input  logic [1:0]        mode,
  input  logic [LANE_W-1:0] stat_byte,
  input  logic [DW-1:0]     array_rdata,
  output logic [DW-1:0]     rdata
);
  import flag_gen_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic used;
    assign used = (k < lanes_used(mode, LANES));
    assign rdata[k*LANE_W +: LANE_W] =
      !active ? array_rdata[k*LANE_W +: LANE_W] :
      used    ? stat_byte : '0;
  end

endmodule

// File: rtl/flag_gen_top.sv
module flag_gen_top #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_erase,
  input  logic          wr_bit7,
  input  logic          eng_busy,
  input  logic          eng_timeout,
  input  logic          win_open,
  input  logic          rd_strobe,
  input  logic          abort_cmd,
  input  logic [1:0]    lane_mode,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] rdata,
  output logic          status_on
);
  import flag_gen_pkg::*;

  logic       tgl_q, tout_q, phase_q;
  logic       active;
  logic [7:0] stat8;
  logic [LANE_W-1:0] stat_lane;

  assign active    = eng_busy | win_open | tout_q;
  assign status_on = active;

  flag_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .rd_strobe   (rd_strobe),
    .eng_timeout (eng_timeout),
    .op_erase    (op_erase),
    .abort_cmd   (abort_cmd),
    .tgl_q       (tgl_q),
    .tout_q      (tout_q),
    .phase_q     (phase_q)
  );

  assign stat8 = make_status(op_erase, wr_bit7, tgl_q, tout_q, phase_q, ~win_open);

  if (LANE_W > 8) begin : g_wide
    assign stat_lane = {{(LANE_W-8){1'b0}}, stat8};
  end else begin : g_narrow
    assign stat_lane = stat8[LANE_W-1:0];
  end

  lane_fanout #(.LANES(LANES), .LANE_W(LANE_W)) u_fan (
    .active      (active),
    .mode        (lane_mode),
    .stat_byte   (stat_lane),
    .array_rdata (array_rdata),
    .rdata       (rdata)
  );

endmodule

// File: rtl/flag_gen_chk.sv
module flag_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_erase,
  input logic        wr_bit7,
  input logic        eng_timeout,
  input logic        rd_strobe,
  input logic        abort_cmd,
  input logic [31:0] array_rdata,
  input logic [31:0] rdata,
  input logic        status_on,
  input logic        tout_q
);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !status_on |-> rdata == array_rdata); // R1
  AST_PROG_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    status_on && !op_erase |-> rdata[7] == ~wr_bit7); // R2
  AST_ERASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    status_on && op_erase |-> !rdata[7]); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    status_on && rd_strobe |=> !status_on || rdata[6] != $past(rdata[6])); // R4
  AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_timeout && !abort_cmd |=> status_on && rdata[5]); // R5
  AST_PHASE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    eng_timeout && !abort_cmd |=> rdata[4] == $past(op_erase)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_on |-> rdata[2:0] == 3'b000); // R8
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cmd |=> !tout_q); // R11

endmodule

bind flag_gen_top flag_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_erase    (op_erase),
  .wr_bit7     (wr_bit7),
  .eng_timeout (eng_timeout),
  .rd_strobe   (rd_strobe),
  .abort_cmd   (abort_cmd),
  .array_rdata (array_rdata),
  .rdata       (rdata),
  .status_on   (status_on),
  .tout_q      (tout_q)
);

// File: tb/sim_flag_gen_top.sv
module sim_flag_gen_top;
  logic clk = 0;
  logic rst_n = 0;
  logic op_erase = 0, wr_bit7 = 0, eng_busy = 0, eng_timeout = 0;
  logic win_open = 0, rd_strobe = 0, abort_cmd = 0;
  logic [1:0]  lane_mode = 2'd2;
  logic [31:0] array_rdata = '0;
  logic [31:0] rdata;
  logic        status_on;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_gen_top u0 (.*);

  // {mode, erase, wd7, busy, win, array, expected}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h8080_8080},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0080},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_8080},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0808_0808},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0808_0808},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0808}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic b6;
    tick(); tick();
    rst_n = 1; #1;
    // R10: reset state, toggle 0 and no timeout
    eng_busy = 1; lane_mode = 2'd0; #1;
    check("R10 reset", rdata, 32'h0000_0080);
    eng_busy = 0; #1;

    for (int i = 0; i < NV; i++) begin
      {lane_mode, op_erase, wr_bit7, eng_busy, win_open, array_rdata} = VEC[i][69:32];
      #1;
      check("R1/R2/R3/R7/R8/R9 vector", rdata, VEC[i][31:0]);
    end

    // R4: toggling on strobes
    op_erase = 0; wr_bit7 = 1; eng_busy = 1; win_open = 0; lane_mode = 2'd2; #1;
    b6 = rdata[6];
    check("R4 initial toggle", {31'd0, b6}, 32'd0);
    rd_strobe = 1; tick();
    check("R4 flip1", {31'd0, rdata[6]}, {31'd0, ~b6});
    tick();
    check("R4 flip2", {31'd0, rdata[6]}, {31'd0, b6});
    rd_strobe = 0; tick(); tick();
    check("R4 hold", {31'd0, rdata[6]}, {31'd0, b6});
    // R4: strobe while inactive has no effect
    eng_busy = 0; rd_strobe = 1; tick(); tick(); rd_strobe = 0;
    eng_busy = 1; #1;
    check("R4 idle strobe ignored", {31'd0, rdata[6]}, {31'd0, b6});

    // R5/R6: program timeout
    eng_timeout = 1; tick(); eng_timeout = 0;
    check("R5 R6 program timeout", rdata, 32'h2020_2020);
    eng_busy = 0; tick(); tick();
    check("R5 held after busy drop", {31'd0, status_on}, 32'd1);
    check("R5 word after busy drop", rdata, 32'h2020_2020);
    abort_cmd = 1; tick(); abort_cmd = 0; array_rdata = 32'hA5A5_5A5A; #1;
    check("R5 abort releases", rdata, 32'hA5A5_5A5A);

    // R6: erase timeout phase
    op_erase = 1; eng_busy = 1; eng_timeout = 1; tick(); eng_timeout = 0;
    check("R6 erase phase", rdata, 32'h3838_3838);
    abort_cmd = 1; eng_busy = 0; tick(); abort_cmd = 0;

    // R11: abort and timeout same edge
    eng_busy = 1; eng_timeout = 1; abort_cmd = 1; tick();
    eng_timeout = 0; abort_cmd = 0; eng_busy = 0; #1;
    check("R11 abort wins", {31'd0, status_on}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule